// File: doc/BRIEF.md
# QPSK Modulator with Direct Digital Synthesis Carrier

The block turns a serial bit stream into a QPSK-modulated digital carrier sample stream. Arriving bits are grouped in twos: the first bit of each pair sets the polarity of the in-phase (cosine) carrier and the second sets the polarity of the quadrature (sine) carrier. Both carriers come from one 32-bit phase accumulator. The accumulator's top bits address a single sine table, and the cosine is read a quarter turn further along in the same table.

Each carrier is passed unchanged or exactly negated according to its data bit. The two signed legs are added in a summer one bit wider than a leg, so the sum can never wrap. Only one clock is used. The symbol rate comes from a programmable divider that raises a one-cycle symbol strobe. Both polarities are loaded together on that strobe, and the strobe is also given to the bit source so that it can pace its bits.

Top module: `qpsk_dds_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator goes to zero, the bit-pairing state returns to "expecting the first bit of a pair", the stored pair and both polarities go to 0, `samp_out` goes to 0 and `samp_vld` goes low.
- R2: At every edge out of reset, the phase accumulator adds `tune_word` modulo 2^32. Its top 8 bits form the table index k.
- R3: The sine table holds, at index k (0..255), round(8192·sin(2πk/256)) as a 15-bit two's-complement value. The cosine sample for index k is the table entry at (k+64) mod 256.
- R4: The first bit of each accepted pair (`bit_vld` high) controls the in-phase (cosine) leg. The second bit controls the quadrature (sine) leg.
- R5: A data bit of 0 passes its carrier sample unchanged. A data bit of 1 replaces it with its exact arithmetic negative, so a cosine peak of +8192 becomes −8192.
- R6: `samp_out` is the 16-bit signed sum of the two legs and never wraps. For in-phase and quadrature at 45° with equal bits, the output reaches +11586 and −11586.
- R7: `sym_tick` is high for one cycle in every `sym_div`+1 cycles (for `sym_div` ≥ 1). The polarities change only at an edge where `sym_tick` is high, and both change at that same edge.
- R8: `samp_out` at edge t reflects the accumulator and polarities as they stood after edge t−3. `samp_vld` rises at the third edge after reset is released and then stays high.
- R9: A lone first bit that has no partner yet does not change the pair that is loaded on a strobe. The next accepted bit completes the pair with that lone bit in the in-phase position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for data and carrier |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | `bit_in` is taken at this edge |
| tune_word | input | 32 | Phase increment per clock |
| sym_div | input | 16 | Symbol period minus one, in clocks |
| sym_tick | output | 1 | Symbol strobe; polarities load at this edge |
| samp_out | output | 16 | Signed modulated sample, I + Q |
| samp_vld | output | 1 | Pipeline filled since reset |

## Verification
The output sample is due exactly three edges after the accumulator value and polarity pair that produce it: one edge for the table read, one for sign control and one for the sum. The bench models the accumulator and the loaded pair at each rising edge, passes its predicted sample through a three-deep delay chain and compares at the falling edge, so each comparison uses the value settled after the third edge. A polarity is loaded at the edge where the strobe was seen high, so the bench hands over a new pair only just after a strobe, well before the next one. Valid is checked at the first, second and third falling edges after reset is released.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;
    localparam int PHASE_W = 32;
    localparam int ADDR_W  = 8;
    localparam int SAMP_W  = 15;
    localparam int AMP     = 8192;
    localparam int DIV_W   = 16;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int QUARTER = DEPTH / 4;
    localparam int SUM_W   = SAMP_W + 1;
    localparam int LAT     = 3;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic i_bit;
        logic q_bit;
    } sym_t;

    typedef struct packed {
        samp_t cos_s;
        samp_t sin_s;
        sym_t  sym;
    } tap_t;

    // Rounded sine code for table entry k of a table with depth n.
    function automatic int sine_code(int k, int n, int amp);
        real ang;
        ang = 2.0 * 3.141592653589793 * real'(k) / real'(n);
        return $rtoi($floor(real'(amp) * $sin(ang) + 0.5));
    endfunction
endpackage

// File: rtl/qpsk_phase_acc.sv
module qpsk_phase_acc
    import qpsk_pkg::*;
#(
    parameter int PW = PHASE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] tune,
    output logic [AW-1:0] idx
);
    logic [PW-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc + tune;
    end

    assign idx = acc[PW-1 -: AW];

    // R1
    acc_clear_chk: assert property (@(posedge clk) rst |=> acc == '0);

    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> acc == $past(acc) + $past(tune));
endmodule

// File: rtl/qpsk_sine_rom.sv
module qpsk_sine_rom
    import qpsk_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int A   = AMP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] idx,
    input  sym_t          sym_in,
    output tap_t          tap
);
    localparam int N   = 1 << AW;
    localparam int QTR = N / 4;

    samp_t rom [N];

    for (genvar k = 0; k < N; k++) begin : g_rom
        localparam int V = sine_code(k, N, A);
        assign rom[k] = samp_t'(V);
    end

    logic [AW-1:0] cos_idx;
    assign cos_idx = idx + AW'(QTR);

    always_ff @(posedge clk) begin
        if (rst) begin
            tap <= '0;
        end else begin
            tap.sin_s <= rom[idx];
            tap.cos_s <= rom[cos_idx];
            tap.sym   <= sym_in;
        end
    end

    // R3
    tap_range_chk: assert property (@(posedge clk) disable iff (rst)
        tap.sin_s <= A && tap.sin_s >= -A && tap.cos_s <= A && tap.cos_s >= -A);
endmodule

// File: rtl/qpsk_bit_pair.sv
module qpsk_bit_pair
    import qpsk_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_in,
    input  logic          bit_vld,
    input  logic [DW-1:0] sym_div,
    output logic          sym_tick,
    output sym_t          sym
);
    logic          half;
    logic          pend;
    sym_t          pair;
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            half <= 1'b0;
            pend <= 1'b0;
            pair <= '0;
        end else if (bit_vld) begin
            if (!half) begin
                pend <= bit_in;
                half <= 1'b1;
            end else begin
                pair.i_bit <= pend;
                pair.q_bit <= bit_in;
                half       <= 1'b0;
            end
        end
    end

    assign sym_tick = (cnt >= sym_div);

    always_ff @(posedge clk) begin
        if (rst || sym_tick) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           sym <= '0;
        else if (sym_tick) sym <= pair;
    end

    // R7
    sym_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sym_tick)) |-> $stable(sym));

    // R9
    lone_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bit_vld) && !$past(half)) |-> $stable(pair));
endmodule

// File: rtl/qpsk_dds_mod.sv
module qpsk_dds_mod
    import qpsk_pkg::*;
#(
    parameter int PW = PHASE_W,
    parameter int DW = DIV_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_in,
    input  logic                    bit_vld,
    input  logic [PW-1:0]           tune_word,
    input  logic [DW-1:0]           sym_div,
    output logic                    sym_tick,
    output logic signed [SUM_W-1:0] samp_out,
    output logic                    samp_vld
);
    logic [ADDR_W-1:0] idx;
    sym_t              sym;
    tap_t              tap;
    samp_t             i_leg, q_leg;
    logic [LAT-1:0]    vld_sr;

    qpsk_phase_acc #(.PW(PW), .AW(ADDR_W)) u_acc (
        .clk(clk), .rst(rst), .tune(tune_word), .idx(idx)
    );

    qpsk_bit_pair #(.DW(DW)) u_pair (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
        .sym_div(sym_div), .sym_tick(sym_tick), .sym(sym)
    );

    qpsk_sine_rom #(.AW(ADDR_W), .A(AMP)) u_rom (
        .clk(clk), .rst(rst), .idx(idx), .sym_in(sym), .tap(tap)
    );

    // Sign control: true negation keeps the peak exact.
    always_ff @(posedge clk) begin
        if (rst) begin
            i_leg <= '0;
            q_leg <= '0;
        end else begin
            i_leg <= tap.sym.i_bit ? -tap.cos_s : tap.cos_s;
            q_leg <= tap.sym.q_bit ? -tap.sin_s : tap.sin_s;
        end
    end

    // Widened summer.
    always_ff @(posedge clk) begin
        if (rst) samp_out <= '0;
        else     samp_out <= sum_t'(i_leg) + sum_t'(q_leg);
    end

    always_ff @(posedge clk) begin
        if (rst) vld_sr <= '0;
        else     vld_sr <= {vld_sr[LAT-2:0], 1'b1};
    end
    assign samp_vld = vld_sr[LAT-1];

    // R5
    leg_range_chk: assert property (@(posedge clk) disable iff (rst)
        i_leg <= AMP && i_leg >= -AMP && q_leg <= AMP && q_leg >= -AMP);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(i_leg) >= 0 && $past(q_leg) >= 0) |-> samp_out >= 0);

    // R6
    sum_range_chk: assert property (@(posedge clk) disable iff (rst)
        samp_out <= 2 * AMP && samp_out >= -2 * AMP);

    // R8
    vld_hold_chk: assert property (@(posedge clk) disable iff (rst)
        samp_vld |=> samp_vld);
endmodule

// File: tb/qpsk_dds_mod_tb.sv
module qpsk_dds_mod_tb;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bit_in = 1'b0;
    logic               bit_vld = 1'b0;
    logic [31:0]        tune_word = '0;
    logic [15:0]        sym_div = 16'd4;
    logic               sym_tick;
    logic signed [15:0] samp_out;
    logic               samp_vld;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    qpsk_dds_mod u_dut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
        .tune_word(tune_word), .sym_div(sym_div), .sym_tick(sym_tick),
        .samp_out(samp_out), .samp_vld(samp_vld)
    );

    // Reference: R3 table, R4 leg mapping, R5 sign, R6 sum.
    function automatic int tab(int k);
        return $rtoi($floor(8192.0 * $sin(2.0 * 3.141592653589793 * real'(k % 256) / 256.0) + 0.5));
    endfunction

    function automatic int expect_samp(logic [31:0] ph, logic [1:0] pr);
        int k, c, s;
        k = int'(ph[31:24]);
        c = tab(k + 64);
        s = tab(k);
        if (pr[1]) c = -c;
        if (pr[0]) s = -s;
        return c + s;
    endfunction

    logic [31:0] m_acc;
    logic [1:0]  m_sym;    // {in-phase bit, quadrature bit}
    logic [1:0]  exp_pair;
    int d1, d2, d3;

    always @(posedge clk) begin
        if (rst) begin
            m_acc <= '0;
            m_sym <= 2'b00;
        end else begin
            m_acc <= m_acc + tune_word;
            if (sym_tick) m_sym <= exp_pair;
        end
        d1 <= expect_samp(m_acc, m_sym);
        d2 <= d1;
        d3 <= d2;
    end

    logic mon_en = 1'b0;
    int   pk_max, pk_min;

    always @(negedge clk) begin
        if (mon_en && !rst && samp_vld) begin
            checks++;
            if (int'(samp_out) != d3) begin
                fails++;
                $display("FAIL R2 R3 R4 R5 R8 sample: got %0d exp %0d", samp_out, d3);
            end
            if (int'(samp_out) > pk_max) pk_max = int'(samp_out);
            if (int'(samp_out) < pk_min) pk_min = int'(samp_out);
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_vld = 1'b0;
        exp_pair = 2'b00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        pk_max = -100000;
        pk_min = 100000;
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (!sym_tick) @(negedge clk);
    endtask

    task automatic send_pair(input logic bi, input logic bq);
        @(negedge clk);
        bit_in = bi; bit_vld = 1'b1;
        @(negedge clk);
        bit_in = bq;
        exp_pair = {bi, bq};
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_one(input logic b);
        @(negedge clk);
        bit_in = b; bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    // {tune, div, i bit, q bit}
    localparam logic [41:0] VEC [6] = '{
        {32'h0000_0000, 8'd4,  1'b0, 1'b0},
        {32'h0000_0000, 8'd5,  1'b1, 1'b0},
        {32'h2000_0000, 8'd4,  1'b1, 1'b1},
        {32'h0100_0000, 8'd7,  1'b0, 1'b1},
        {32'h1234_5678, 8'd6,  1'b1, 1'b0},
        {32'h2000_0000, 8'd9,  1'b0, 1'b0}
    };

    initial begin
        exp_pair = 2'b00;
        pk_max = -100000;
        pk_min = 100000;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 samp_out in reset", int'(samp_out), 0);
        check("R1 samp_vld in reset", int'(samp_vld), 0);

        // R8: valid latency after release
        rst = 1'b0;
        @(negedge clk);
        check("R8 vld edge1", int'(samp_vld), 0);
        @(negedge clk);
        check("R8 vld edge2", int'(samp_vld), 0);
        @(negedge clk);
        check("R8 vld edge3", int'(samp_vld), 1);

        mon_en = 1'b1;
        for (int v = 0; v < 6; v++) begin
            tune_word = VEC[v][41:10];
            sym_div   = 16'(VEC[v][9:2]);
            do_reset();
            wait_tick();
            send_pair(VEC[v][1], VEC[v][0]);
            wait_tick();
            repeat (4 * (int'(VEC[v][9:2]) + 1) + 12) @(negedge clk);
            if (v == 5) begin
                check("R6 positive peak", pk_max, 11586);
                check("R6 negative peak", pk_min, -11586);
            end
        end

        // R4/R5: fixed phase k=0, cosine +8192, sine 0
        tune_word = '0;
        sym_div = 16'd4;
        do_reset();
        wait_tick();
        send_pair(1'b1, 1'b0);
        wait_tick();
        repeat (5) @(negedge clk);
        check("R4 R5 first bit negates in-phase", int'(samp_out), -8192);
        wait_tick();
        send_pair(1'b0, 1'b1);
        wait_tick();
        repeat (5) @(negedge clk);
        check("R4 second bit leaves cosine", int'(samp_out), 8192);

        // R7: strobe period
        sym_div = 16'd5;
        do_reset();
        wait_tick();
        begin
            int gap = 0;
            @(negedge clk); gap++;
            while (!sym_tick) begin @(negedge clk); gap++; end
            check("R7 strobe period", gap, 6);
        end

        // R7: polarity held until strobe
        tune_word = '0;
        sym_div = 16'd12;
        do_reset();
        wait_tick();
        send_pair(1'b1, 1'b1);
        repeat (5) @(negedge clk);
        check("R7 polarity held before strobe", int'(samp_out), 8192);
        wait_tick();
        repeat (4) @(negedge clk);
        check("R7 polarity after strobe", int'(samp_out), -8192);

        // R9: lone bit does not disturb loaded pair, then completes a pair
        sym_div = 16'd4;
        do_reset();
        wait_tick();
        send_pair(1'b1, 1'b0);
        wait_tick();
        send_one(1'b0);
        wait_tick();
        wait_tick();
        repeat (4) @(negedge clk);
        check("R9 lone bit ignored", int'(samp_out), -8192);
        send_one(1'b0);   // completes pair {0,0}
        exp_pair = 2'b00;
        wait_tick();
        repeat (4) @(negedge clk);
        check("R9 lone bit becomes in-phase", int'(samp_out), 8192);

        // R1: reset clears a pending first bit
        do_reset();
        wait_tick();
        send_one(1'b0);
        do_reset();
        wait_tick();
        send_pair(1'b1, 1'b0);
        wait_tick();
        repeat (4) @(negedge clk);
        check("R1 pairing restarts after reset", int'(samp_out), -8192);

        mon_en = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule